// File: doc/BRIEF.md
# Cubic Bezier Subdivision Flattener

This block turns a cubic Bezier curve with four integer control points into a chain of straight line segments. It splits the curve at its parametric midpoint repeatedly, down to a depth chosen by the caller. Every sub-curve that reaches that depth becomes one segment, from its first control point to its last. No flatness test is applied, so every branch of the subdivision tree has the same depth. A curve given with depth d therefore produces exactly 2^d segments, in order along the curve.

A caller presents the eight coordinates and the depth, then raises `start` while `in_ready` is high. The block holds the sub-curves that are still waiting in an explicit stack. Each entry holds the control points of one sub-curve and its level. On every working cycle the block does one of two things with the top entry. If the entry is not yet at the target depth, it splits the entry, leaving the right half underneath and the left half on top. If the entry is at the target depth, it offers the entry as a segment on a valid/ready stream and pops it once the segment is taken. The x and y coordinates pass through two identical integer midpoint datapaths that always act together.

Top module: `bezier_flattener`

## Requirements
- R1: After reset, `in_ready` is 1 and `seg_valid` is 0.
- R2: A curve is accepted on a rising clock edge where `start` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 until the edge where the last segment is taken. While `in_ready` is 1, `seg_valid` is 0.
- R3: A curve accepted with effective depth d produces exactly 2^d segments. With depth 0, the single segment runs from P1 to P4. The stack never holds more than MAXD+1 entries.
- R4: Each split computes every new point as floor((a+b)/2) of two W-bit two's-complement values, using a W+1-bit sum. The result is exact for coordinates anywhere in the full signed range, including -2^(W-1) and 2^(W-1)-1. From (A,B,C,D) the split forms L2=mid(A,B), H=mid(B,C), R3=mid(C,D), L3=mid(L2,H), R2=mid(H,R3) and M=mid(L3,R2). The left half is (A,L2,L3,M) and the right half is (M,R2,R3,D).
- R5: The left half is always fully emitted before the right half. The first segment starts at P1 and the last one ends at P4. Each segment starts where the previous one ended.
- R6: While `seg_valid` is 1 and `seg_ready` is 0, `seg_valid` and all four segment coordinates hold. No segment is dropped or repeated.
- R7: A `depth` input larger than MAXD is treated as MAXD.
- R8: A `start` pulse, and any change on the point or depth inputs, while `in_ready` is 0 has no effect on the current curve's segments.
- R9: The x and y coordinates are computed by two identical datapaths. Each output x (or y) depends only on the x (or y) inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to accept a new curve |
| in_ready | output | 1 | Block is idle and can accept a curve |
| depth | input | DW | Requested subdivision depth (clamped to MAXD) |
| p1_x | input | W | First control point, x (signed) |
| p1_y | input | W | First control point, y (signed) |
| p2_x | input | W | Second control point, x |
| p2_y | input | W | Second control point, y |
| p3_x | input | W | Third control point, x |
| p3_y | input | W | Third control point, y |
| p4_x | input | W | Fourth control point, x |
| p4_y | input | W | Fourth control point, y |
| seg_valid | output | 1 | A segment is offered |
| seg_ready | input | 1 | Consumer takes the offered segment |
| seg_x0 | output | W | Segment start, x |
| seg_y0 | output | W | Segment start, y |
| seg_x1 | output | W | Segment end, x |
| seg_y1 | output | W | Segment end, y |

## Verification
The stack pointer, the level tags and the stored points feed the output directly, so a fault in any of them shows at the ports within the same curve. The first segment after it will have the wrong endpoint, or the segment count will be wrong, or the chain will break where a start no longer equals the previous end. A stack entry overwritten too early changes a later segment, often many cycles after the fault. For this reason every segment of every curve is compared with a reference subdivision built level by level. These curves use depths 0 to MAXD, depths that must be clamped, coordinates at both ends of the signed range, and random stalls on `seg_ready`.

// File: rtl/bezier_flattener.sv
module bezier_flattener #(
  parameter int W    = 16,
  parameter int MAXD = 6,
  localparam int DW  = $clog2(MAXD + 1),
  localparam int SPW = $clog2(MAXD + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                in_ready,
  input  logic [DW-1:0]       depth,
  input  logic signed [W-1:0] p1_x,
  input  logic signed [W-1:0] p1_y,
  input  logic signed [W-1:0] p2_x,
  input  logic signed [W-1:0] p2_y,
  input  logic signed [W-1:0] p3_x,
  input  logic signed [W-1:0] p3_y,
  input  logic signed [W-1:0] p4_x,
  input  logic signed [W-1:0] p4_y,
  output logic                seg_valid,
  input  logic                seg_ready,
  output logic signed [W-1:0] seg_x0,
  output logic signed [W-1:0] seg_y0,
  output logic signed [W-1:0] seg_x1,
  output logic signed [W-1:0] seg_y1
);

  function automatic logic signed [W-1:0] mid(input logic signed [W-1:0] a,
                                              input logic signed [W-1:0] b);
    logic signed [W:0] s;
    s = {a[W-1], a} + {b[W-1], b};
    return s[W:1];
  endfunction

  logic signed [W-1:0] stk [0:MAXD][0:1][0:3];
  logic [DW-1:0]       lvl [0:MAXD];
  logic [DW-1:0]       dep;
  logic [SPW-1:0]      sp;
  logic                busy;

  logic [SPW-1:0]      top, nxt;
  logic signed [W-1:0] in_pt [0:1][0:3];
  logic signed [W-1:0] lh    [0:1][0:3];
  logic signed [W-1:0] rh    [0:1][0:3];
  logic                leaf;

  assign top  = (sp == '0) ? '0 : sp - 1'b1;
  assign nxt  = top + 1'b1;
  assign leaf = (lvl[top] == dep);

  assign in_pt[0][0] = p1_x;  assign in_pt[1][0] = p1_y;
  assign in_pt[0][1] = p2_x;  assign in_pt[1][1] = p2_y;
  assign in_pt[0][2] = p3_x;  assign in_pt[1][2] = p3_y;
  assign in_pt[0][3] = p4_x;  assign in_pt[1][3] = p4_y;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    logic signed [W-1:0] l2, h, r3, l3, r2, m;
    assign l2 = mid(stk[top][a][0], stk[top][a][1]);
    assign h  = mid(stk[top][a][1], stk[top][a][2]);
    assign r3 = mid(stk[top][a][2], stk[top][a][3]);
    assign l3 = mid(l2, h);
    assign r2 = mid(h, r3);
    assign m  = mid(l3, r2);
    assign lh[a][0] = stk[top][a][0];
    assign lh[a][1] = l2;
    assign lh[a][2] = l3;
    assign lh[a][3] = m;
    assign rh[a][0] = m;
    assign rh[a][1] = r2;
    assign rh[a][2] = r3;
    assign rh[a][3] = stk[top][a][3];
  end

  assign in_ready  = !busy;
  assign seg_valid = busy && leaf;
  assign seg_x0    = stk[top][0][0];
  assign seg_y0    = stk[top][1][0];
  assign seg_x1    = stk[top][0][3];
  assign seg_y1    = stk[top][1][3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sp   <= '0;
      dep  <= '0;
    end else if (!busy) begin
      if (start) begin
        for (int a = 0; a < 2; a++)
          for (int k = 0; k < 4; k++)
            stk[0][a][k] <= in_pt[a][k];
        lvl[0] <= '0;
        dep    <= (int'(depth) > MAXD) ? DW'(MAXD) : depth;
        sp     <= SPW'(1);
        busy   <= 1'b1;
      end
    end else if (leaf) begin
      if (seg_ready) begin
        sp <= sp - 1'b1;
        if (sp == SPW'(1)) busy <= 1'b0;
      end
    end else begin
      for (int a = 0; a < 2; a++)
        for (int k = 0; k < 4; k++) begin
          stk[top][a][k] <= rh[a][k];
          stk[nxt][a][k] <= lh[a][k];
        end
      lvl[top] <= lvl[top] + 1'b1;
      lvl[nxt] <= lvl[top] + 1'b1;
      sp       <= sp + 1'b1;
    end
  end

  logic                have_prev;
  logic signed [W-1:0] prev_x1, prev_y1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_x1   <= '0;
      prev_y1   <= '0;
    end else if (start && in_ready) begin
      have_prev <= 1'b0;
    end else if (seg_valid && seg_ready) begin
      have_prev <= 1'b1;
      prev_x1   <= seg_x1;
      prev_y1   <= seg_y1;
    end
  end

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_x0) && $stable(seg_y0)
                                && $stable(seg_x1) && $stable(seg_y1)); // R6

  AST_IDLE_NO_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !seg_valid); // R2

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sp != '0) && (int'(sp) <= MAXD + 1)); // R3

  AST_PATH_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && have_prev |-> seg_x0 == prev_x1 && seg_y0 == prev_y1); // R5

endmodule

// File: tb/bezier_flattener_tb.sv
module bezier_flattener_tb;
  localparam int W    = 8;
  localparam int MAXD = 4;
  localparam int DW   = $clog2(MAXD + 1);

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic in_ready;
  logic [DW-1:0] depth = '0;
  logic signed [W-1:0] p1_x = 0, p1_y = 0, p2_x = 0, p2_y = 0;
  logic signed [W-1:0] p3_x = 0, p3_y = 0, p4_x = 0, p4_y = 0;
  logic seg_valid;
  logic seg_ready = 0;
  logic signed [W-1:0] seg_x0, seg_y0, seg_x1, seg_y1;

  always #4 clk = ~clk;

  bezier_flattener #(.W(W), .MAXD(MAXD)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready), .depth(depth),
    .p1_x(p1_x), .p1_y(p1_y), .p2_x(p2_x), .p2_y(p2_y),
    .p3_x(p3_x), .p3_y(p3_y), .p4_x(p4_x), .p4_y(p4_y),
    .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_x0(seg_x0), .seg_y0(seg_y0), .seg_x1(seg_x1), .seg_y1(seg_y1));

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int md(input int a, input int b);
    return (a + b) >>> 1;
  endfunction

  int cx [0:15][0:3];
  int cy [0:15][0:3];
  int gx0 [0:31], gy0 [0:31], gx1 [0:31], gy1 [0:31];

  task automatic split_all(input int d);
    for (int lev = 0; lev < d; lev++) begin
      for (int i = (1 << lev) - 1; i >= 0; i--) begin
        int a0, a1, a2, a3, b0, b1, b2, b3;
        int l2, h, r3, l3, r2, m;
        a0 = cx[i][0]; a1 = cx[i][1]; a2 = cx[i][2]; a3 = cx[i][3];
        l2 = md(a0, a1); h = md(a1, a2); r3 = md(a2, a3);
        l3 = md(l2, h); r2 = md(h, r3); m = md(l3, r2);
        cx[2*i][0] = a0; cx[2*i][1] = l2; cx[2*i][2] = l3; cx[2*i][3] = m;
        cx[2*i+1][0] = m; cx[2*i+1][1] = r2; cx[2*i+1][2] = r3; cx[2*i+1][3] = a3;
        b0 = cy[i][0]; b1 = cy[i][1]; b2 = cy[i][2]; b3 = cy[i][3];
        l2 = md(b0, b1); h = md(b1, b2); r3 = md(b2, b3);
        l3 = md(l2, h); r2 = md(h, r3); m = md(l3, r2);
        cy[2*i][0] = b0; cy[2*i][1] = l2; cy[2*i][2] = l3; cy[2*i][3] = m;
        cy[2*i+1][0] = m; cy[2*i+1][1] = r2; cy[2*i+1][2] = r3; cy[2*i+1][3] = b3;
      end
    end
  endtask

  // xs/ys: control points; stall: random seg_ready; junk: start with other inputs while busy (R8)
  task automatic run_curve(input int xs[4], input int ys[4], input int d_in,
                           input bit stall, input bit junk);
    int d, n, cyc;
    bit held;
    int hx0, hy0, hx1, hy1;
    d = (d_in > MAXD) ? MAXD : d_in;
    for (int k = 0; k < 4; k++) begin cx[0][k] = xs[k]; cy[0][k] = ys[k]; end
    split_all(d);
    @(negedge clk);
    p1_x = W'(xs[0]); p2_x = W'(xs[1]); p3_x = W'(xs[2]); p4_x = W'(xs[3]);
    p1_y = W'(ys[0]); p2_y = W'(ys[1]); p3_y = W'(ys[2]); p4_y = W'(ys[3]);
    depth = DW'(d_in);
    start = 1;
    seg_ready = 0;
    @(negedge clk);
    if (junk) begin
      p1_x = 5; p2_x = -7; p3_x = 99; p4_x = -99;
      p1_y = -3; p2_y = 44; p3_y = -60; p4_y = 17;
      depth = '0;
    end else start = 0;
    n = 0; cyc = 0; held = 0;
    while (1) begin
      if (cyc >= 1) start = 0;
      seg_ready = stall ? 1'($urandom % 2) : 1'b1;
      #1;
      if (cyc == 0) chk("R2 in_ready low while busy", int'(in_ready), 0);
      if (held) begin
        chk("R6 valid held under stall", int'(seg_valid), 1);
        chk("R6 coords held under stall",
            int'(seg_x0 == hx0 && seg_y0 == hy0 && seg_x1 == hx1 && seg_y1 == hy1), 1);
      end
      held = 0;
      if (in_ready) break;
      if (seg_valid && seg_ready) begin
        if (n < 32) begin
          gx0[n] = seg_x0; gy0[n] = seg_y0; gx1[n] = seg_x1; gy1[n] = seg_y1;
        end
        n++;
      end else if (seg_valid) begin
        held = 1; hx0 = seg_x0; hy0 = seg_y0; hx1 = seg_x1; hy1 = seg_y1;
      end
      cyc++;
      @(negedge clk);
      if (cyc > 2000) break;
    end
    seg_ready = 0;
    chk("R3 segment count", n, 1 << d);
    if (d_in > MAXD) chk("R7 clamped count", n, 1 << MAXD);
    if (n == (1 << d)) begin
      chk("R5 first start x", gx0[0], xs[0]);
      chk("R5 first start y", gy0[0], ys[0]);
      chk("R5 last end x", gx1[n-1], xs[3]);
      chk("R5 last end y", gy1[n-1], ys[3]);
      for (int i = 0; i < n; i++) begin
        chk(junk ? "R8 seg x0 unaffected" : "R4 seg x0", gx0[i], cx[i][0]);
        chk("R9 seg y0", gy0[i], cy[i][0]);
        chk("R4 seg x1", gx1[i], cx[i][3]);
        chk("R9 seg y1", gy1[i], cy[i][3]);
      end
    end
  endtask

  initial begin
    int xs[4], ys[4];
    repeat (3) @(negedge clk);
    #1;
    chk("R1 in_ready after reset", int'(in_ready), 1);
    chk("R1 seg_valid after reset", int'(seg_valid), 0);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 in_ready idle", int'(in_ready), 1);

    xs = '{-128, 127, -128, 127}; ys = '{127, -128, 127, -128};
    for (int d = 0; d <= MAXD; d++) run_curve(xs, ys, d, 0, 0);
    xs = '{127, 127, 127, 127}; ys = '{-128, -128, -128, -128};
    run_curve(xs, ys, MAXD, 1, 0);
    xs = '{0, 10, 20, 30}; ys = '{0, 0, 0, 0};
    run_curve(xs, ys, 0, 1, 0);
    xs = '{-1, -1, 0, 1}; ys = '{3, -5, 7, -9};
    run_curve(xs, ys, 7, 1, 0);
    run_curve(xs, ys, 5, 0, 1);
    for (int t = 0; t < 60; t++) begin
      for (int k = 0; k < 4; k++) begin
        xs[k] = int'($urandom % 256) - 128;
        ys[k] = int'($urandom % 256) - 128;
      end
      run_curve(xs, ys, int'($urandom % 8), t % 2 == 0, (t % 3 == 0));
    end
    // R3: depth 0 on this curve is a single segment P1->P4
    xs = '{-50, 60, -70, 80}; ys = '{1, 2, 3, 4};
    run_curve(xs, ys, 0, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule